// File: doc/BRIEF.md
# I/Q Serial Output Formatter

This block turns pairs of already-filtered in-phase and quadrature samples into a single-wire serial stream. Alongside the data it produces a free-running serial clock and a frame-sync strobe. Each pair goes out as two words of `SAMPLE_W+1` bits, 16 at the defaults. The in-phase word always comes first. Each word carries its sample most significant bit first, then a one-bit tag that says which component the word holds.

A new pair is offered with a one-cycle `pair_valid` pulse. The pair being shifted sits in the shift register, and one further pair can wait in a single-entry buffer. A pair that arrives while that buffer is occupied replaces the waiting pair and raises a sticky overrun flag.

A rate input selects the serial clock speed. A high rate input gives four samples per symbol and a fast clock. A low rate input gives two samples per symbol and halves the clock, so pairs go out at half the rate. An output-enable input releases the data pin to high impedance.

Top module: `iq_serial_fmt`

## Requirements
- R1: Each word is `SAMPLE_W+1` bits long. Its first `SAMPLE_W` bits are the sample in two's complement, most significant bit first, and its last bit is the component tag.
- R2: Within a pair, the in-phase word is sent first and the quadrature word follows immediately. The pair occupies `2*(SAMPLE_W+1)` consecutive bit periods.
- R3: The tag bit is 0 on the in-phase word and 1 on the quadrature word.
- R4: `ser_data` changes only on a rising edge of `ser_clk`, so it is stable at every falling edge, where the receiver samples it.
- R5: `ser_fsync` is high for exactly one `ser_clk` period, the period just before the first in-phase bit, and is low during every data bit.
- R6: With `rate_4x` high the `ser_clk` period is `2*HALF_FAST` clock cycles. With `rate_4x` low it is `4*HALF_FAST` clock cycles. A new rate takes effect at the next bit-period boundary.
- R7: With `out_en` low, `ser_data_oe` is 0 and `ser_data` is released to high impedance. With `out_en` high the data is driven and the stream continues.
- R8: A pair that arrives while another is being shifted is held. It is sent starting in the bit period right after the last bit of the current pair, with no idle period between the two pairs.
- R9: A pair that arrives while the holding buffer is full overwrites the held pair, which is never sent. This sets `overrun`, and `overrun` stays set until reset.
- R10: After reset, `ser_fsync`, `ser_data` and `overrun` are 0.
- R11: With no pair waiting, the block sends no frame sync and drives `ser_data` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pair_valid | input | 1 | One-cycle strobe: `i_sample`/`q_sample` hold a new pair |
| i_sample | input | SAMPLE_W | In-phase sample, two's complement |
| q_sample | input | SAMPLE_W | Quadrature sample, two's complement |
| rate_4x | input | 1 | 1: four samples per symbol (fast clock), 0: two (half-speed clock) |
| out_en | input | 1 | 1: drive `ser_data`; 0: release it |
| ser_clk | output | 1 | Serial bit clock |
| ser_fsync | output | 1 | Frame sync, one bit period ahead of each pair |
| ser_data | output | 1 | Serial data, high impedance when disabled |
| ser_data_oe | output | 1 | High while `ser_data` is driven |
| overrun | output | 1 | Sticky flag: a held pair was overwritten |

## Verification
A pair strobed in is loaded into the shift register at the next bit-period boundary, at most one `ser_clk` period plus one cycle later. Its frame sync then lasts one period, and each data bit is valid at the following falling edges of `ser_clk`. Because the start time varies with the divider phase, the bench counts no fixed delays. At each falling clock edge it watches `ser_clk` for a high-to-low transition and samples `ser_data` and `ser_fsync` in that cycle. Back-to-back delivery is checked by requiring frame sync at the very next falling edge after the last quadrature bit. `overrun` is checked a few cycles after the colliding strobe, once its single register has updated. The period is measured as the clock cycles between consecutive `ser_clk` falls, after the divider has settled.

// File: rtl/iq_fmt_pkg.sv
package iq_fmt_pkg;
   typedef enum logic {
      RATE_2X = 1'b0,
      RATE_4X = 1'b1
   } rate_e;

   localparam logic TAG_I = 1'b0;
   localparam logic TAG_Q = 1'b1;
endpackage

// File: rtl/iq_sclk_gen.sv
module iq_sclk_gen #(
   parameter int HALF_FAST = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_4x,
   output logic sclk,
   output logic bit_tick
);
   import iq_fmt_pkg::*;

   localparam int HALF_SLOW = 2 * HALF_FAST;
   localparam int CW        = $clog2(2 * HALF_SLOW);

   logic [CW-1:0] cnt;
   logic          fast_q;
   logic [CW-1:0] last_cnt;
   logic [CW-1:0] half_cnt;

   always_comb begin
      if (fast_q == RATE_4X) begin
         last_cnt = CW'(2 * HALF_FAST - 1);
         half_cnt = CW'(HALF_FAST);
      end else begin
         last_cnt = CW'(2 * HALF_SLOW - 1);
         half_cnt = CW'(HALF_SLOW);
      end
   end

   assign bit_tick = (cnt == last_cnt);
   assign sclk     = (cnt < half_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         fast_q <= RATE_4X;
      end else if (bit_tick) begin
         cnt    <= '0;
         fast_q <= rate_4x;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   // R6: a period boundary always opens with the clock high
   p_tick_high_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_tick |=> sclk);
   // R6: the rate latch only moves at a boundary
   p_rate_at_edge_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fast_q) |-> $rose(sclk));
endmodule

// File: rtl/iq_pair_buf.sv
module iq_pair_buf #(
   parameter int SAMPLE_W = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   input  logic                take,
   output logic                full,
   output logic [SAMPLE_W-1:0] out_i,
   output logic [SAMPLE_W-1:0] out_q,
   output logic                overrun
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         out_i   <= '0;
         out_q   <= '0;
         overrun <= 1'b0;
      end else begin
         if (in_valid) begin
            out_i <= in_i;
            out_q <= in_q;
            full  <= 1'b1;
            if (full && !take) overrun <= 1'b1;
         end else if (take) begin
            full <= 1'b0;
         end
      end
   end

   // R9: once raised, the overrun flag holds until reset
   p_overrun_sticky_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun);
   // R9: overrun only rises on a collision with a held pair
   p_overrun_cause_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(overrun) |-> $past(in_valid) && $past(full));
endmodule

// File: rtl/iq_word_shifter.sv
module iq_word_shifter #(
   parameter int SAMPLE_W = 15
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bit_tick,
   input  logic                buf_full,
   input  logic [SAMPLE_W-1:0] buf_i,
   input  logic [SAMPLE_W-1:0] buf_q,
   output logic                take,
   output logic                fsync,
   output logic                dout
);
   import iq_fmt_pkg::*;

   localparam int WW  = SAMPLE_W + 1;
   localparam int FW  = 2 * WW;
   localparam int SLW = $clog2(FW + 1);

   logic [FW-1:0]  sh;
   logic [SLW-1:0] slot;
   logic           busy;
   logic           at_end;

   assign at_end = !busy || (slot == SLW'(FW));
   assign take   = bit_tick && buf_full && at_end;
   assign fsync  = busy && (slot == '0);
   assign dout   = busy && (slot != '0) && sh[FW-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         slot <= '0;
         busy <= 1'b0;
      end else if (bit_tick) begin
         if (at_end) begin
            slot <= '0;
            busy <= buf_full;
            if (buf_full) sh <= {buf_i, TAG_I, buf_q, TAG_Q};
         end else begin
            slot <= slot + 1'b1;
            if (slot != '0) sh <= sh << 1;
         end
      end
   end

   // R3: the last bit of the in-phase word carries the in-phase tag
   p_tag_i_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      busy && (slot == SLW'(WW)) |-> (dout == TAG_I));
   // R3: the last bit of the quadrature word carries the quadrature tag
   p_tag_q_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      busy && (slot == SLW'(FW)) |-> (dout == TAG_Q));
   // R11: nothing in flight means no sync and a low data line
   p_idle_quiet_r11 : assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !fsync && !dout);
endmodule

// File: rtl/iq_serial_fmt.sv
module iq_serial_fmt #(
   parameter int SAMPLE_W  = 15,
   parameter int HALF_FAST = 2,
   parameter bit TRISTATE  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pair_valid,
   input  logic [SAMPLE_W-1:0] i_sample,
   input  logic [SAMPLE_W-1:0] q_sample,
   input  logic                rate_4x,
   input  logic                out_en,
   output logic                ser_clk,
   output logic                ser_fsync,
   output logic                ser_data,
   output logic                ser_data_oe,
   output logic                overrun
);
   if (SAMPLE_W < 2) begin : g_bad_width
      $error("iq_serial_fmt: SAMPLE_W must be at least 2");
   end
   if (HALF_FAST < 1) begin : g_bad_half
      $error("iq_serial_fmt: HALF_FAST must be at least 1");
   end

   logic                bit_tick;
   logic                take;
   logic                buf_full;
   logic [SAMPLE_W-1:0] buf_i;
   logic [SAMPLE_W-1:0] buf_q;
   logic                dout;

   iq_sclk_gen #(.HALF_FAST(HALF_FAST)) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .rate_4x  (rate_4x),
      .sclk     (ser_clk),
      .bit_tick (bit_tick)
   );

   iq_pair_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (pair_valid),
      .in_i     (i_sample),
      .in_q     (q_sample),
      .take     (take),
      .full     (buf_full),
      .out_i    (buf_i),
      .out_q    (buf_q),
      .overrun  (overrun)
   );

   iq_word_shifter #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_tick (bit_tick),
      .buf_full (buf_full),
      .buf_i    (buf_i),
      .buf_q    (buf_q),
      .take     (take),
      .fsync    (ser_fsync),
      .dout     (dout)
   );

   assign ser_data_oe = out_en;

   if (TRISTATE) begin : g_pin_tri
      assign ser_data = out_en ? dout : 1'bz;
   end else begin : g_pin_low
      assign ser_data = out_en & dout;
   end

   // R4: data moves only together with a rising serial clock
   p_data_on_rise_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(dout) |-> $rose(ser_clk));
   // R5: frame sync starts and ends on rising serial clock edges
   p_fsync_rise_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_fsync) |-> $rose(ser_clk));
   p_fsync_fall_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_fsync) |-> $rose(ser_clk));
   // R8: the shifter only draws from a filled buffer
   p_take_full_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      take |-> buf_full);
endmodule

// File: tb/iq_serial_fmt_tb.sv
module iq_serial_fmt_tb;
   localparam int SW = 15;
   localparam int HF = 2;
   localparam int FW = 2 * (SW + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pair_valid = 1'b0;
   logic [SW-1:0] i_sample = '0;
   logic [SW-1:0] q_sample = '0;
   logic          rate_4x = 1'b1;
   logic          out_en = 1'b1;
   logic          ser_clk, ser_fsync, ser_data, ser_data_oe, overrun;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   iq_serial_fmt #(.SAMPLE_W(SW), .HALF_FAST(HF), .TRISTATE(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid),
      .i_sample(i_sample), .q_sample(q_sample), .rate_4x(rate_4x),
      .out_en(out_en), .ser_clk(ser_clk), .ser_fsync(ser_fsync),
      .ser_data(ser_data), .ser_data_oe(ser_data_oe), .overrun(overrun)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [FW-1:0] frame(input logic [SW-1:0] iv,
                                           input logic [SW-1:0] qv);
      return {iv, 1'b0, qv, 1'b1};
   endfunction

   task automatic wait_fall();
      logic prev;
      @(negedge clk);
      prev = ser_clk;
      forever begin
         @(negedge clk);
         if (prev && !ser_clk) break;
         prev = ser_clk;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      pair_valid = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic send(input logic [SW-1:0] iv, input logic [SW-1:0] qv);
      @(negedge clk);
      i_sample = iv;
      q_sample = qv;
      pair_valid = 1'b1;
      @(negedge clk);
      pair_valid = 1'b0;
   endtask

   // Capture one frame; imm=1 requires the sync at the very next fall.
   task automatic capture(input bit imm, output logic [FW-1:0] bits);
      bits = '0;
      if (imm) begin
         wait_fall();
         chk(ser_fsync == 1'b1, "R8 back-to-back sync", {31'd0, ser_fsync}, 32'd1);
      end else begin
         do wait_fall(); while (!ser_fsync);
      end
      for (int k = 0; k < FW; k++) begin
         wait_fall();
         if (k == 0)
            chk(ser_fsync == 1'b0, "R5 sync low at first bit", {31'd0, ser_fsync}, 32'd0);
         bits = {bits[FW-2:0], ser_data};
      end
   endtask

   task automatic t_reset_idle();
      do_reset();
      @(negedge clk);
      chk(ser_fsync == 1'b0 && ser_data == 1'b0 && overrun == 1'b0, "R10 reset state",
          {29'd0, ser_fsync, ser_data, overrun}, 32'd0);
      begin
         bit quiet = 1'b1;
         for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (ser_fsync || ser_data) quiet = 1'b0;
         end
         chk(quiet, "R11 idle without pairs", {31'd0, quiet}, 32'd1);
      end
   endtask

   task automatic t_single(input logic [SW-1:0] iv, input logic [SW-1:0] qv,
                           input string tag);
      logic [FW-1:0] got;
      fork
         capture(1'b0, got);
         send(iv, qv);
      join
      chk(got == frame(iv, qv), {"R1 R2 word content ", tag}, 32'(got), 32'(frame(iv, qv)));
      chk(got[FW/2] == 1'b0 && got[0] == 1'b1, "R3 tag bits",
          {30'd0, got[FW/2], got[0]}, 32'd1);
   endtask

   task automatic t_period(input bit fast, input int exp);
      int n;
      rate_4x = fast;
      repeat (3) wait_fall();
      n = 0;
      begin
         logic prev;
         @(negedge clk);
         prev = ser_clk;
         n = 1;
         forever begin
            @(negedge clk);
            n++;
            if (prev && !ser_clk) break;
            prev = ser_clk;
         end
      end
      wait_fall();
      chk(1'b1, "R6 settle", 32'd0, 32'd0);
      begin
         int c = 0;
         logic prev2;
         prev2 = ser_clk;
         forever begin
            @(negedge clk);
            c++;
            if (prev2 && !ser_clk) break;
            prev2 = ser_clk;
         end
         chk(c == exp, "R6 serial clock period", 32'(c), 32'(exp));
      end
   endtask

   task automatic t_back_to_back();
      logic [FW-1:0] a, b;
      do_reset();
      fork
         capture(1'b0, a);
         begin
            send(15'h1234, 15'h0F0F);
            repeat (20) @(negedge clk);
            send(15'h7FFF, 15'h4000);
         end
      join
      capture(1'b1, b);
      chk(a == frame(15'h1234, 15'h0F0F), "R8 first pair", 32'(a), 32'(frame(15'h1234, 15'h0F0F)));
      chk(b == frame(15'h7FFF, 15'h4000), "R8 held pair", 32'(b), 32'(frame(15'h7FFF, 15'h4000)));
      chk(overrun == 1'b0, "R9 no overrun with one held", {31'd0, overrun}, 32'd0);
   endtask

   task automatic t_overrun();
      logic [FW-1:0] a, c;
      do_reset();
      fork
         capture(1'b0, a);
         begin
            send(15'h0001, 15'h0002);
            repeat (20) @(negedge clk);
            send(15'h0AAA, 15'h0BBB);
            repeat (3) @(negedge clk);
            send(15'h3C3C, 15'h5A5A);
            repeat (3) @(negedge clk);
            chk(overrun == 1'b1, "R9 overrun set", {31'd0, overrun}, 32'd1);
         end
      join
      capture(1'b1, c);
      chk(a == frame(15'h0001, 15'h0002), "R9 in-flight pair", 32'(a), 32'(frame(15'h0001, 15'h0002)));
      chk(c == frame(15'h3C3C, 15'h5A5A), "R9 newest pair wins", 32'(c), 32'(frame(15'h3C3C, 15'h5A5A)));
      begin
         bit quiet = 1'b1;
         for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (ser_fsync) quiet = 1'b0;
         end
         chk(quiet, "R9 overwritten pair dropped", {31'd0, quiet}, 32'd1);
      end
      chk(overrun == 1'b1, "R9 overrun sticky", {31'd0, overrun}, 32'd1);
   endtask

   task automatic t_output_enable();
      logic [FW-1:0] g;
      out_en = 1'b0;
      repeat (5) @(negedge clk);
      chk(ser_data_oe == 1'b0, "R7 released when disabled", {31'd0, ser_data_oe}, 32'd0);
      out_en = 1'b1;
      @(negedge clk);
      chk(ser_data_oe == 1'b1, "R7 driven when enabled", {31'd0, ser_data_oe}, 32'd1);
      fork
         capture(1'b0, g);
         send(15'h2468, 15'h1357);
      join
      chk(g == frame(15'h2468, 15'h1357), "R7 stream after re-enable", 32'(g), 32'(frame(15'h2468, 15'h1357)));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset_idle();
      t_single(15'h1234, 15'h0F0F, "fast");
      t_single(15'h7FFF, 15'h4000, "extremes");
      t_single(15'h0000, 15'h7FFF, "zero");
      t_period(1'b1, 2 * HF);
      t_period(1'b0, 4 * HF);
      t_single(15'h5555, 15'h2AAA, "slow");
      rate_4x = 1'b1;
      t_back_to_back();
      t_output_enable();
      t_overrun();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule